// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Capture

This block shifts a 32-bit operand left logically, right logically or right arithmetically by a count taken modulo 64, and produces the bit that fell off the end as both the carry flag and the extend flag. Counts equal to or greater than the data width give exact, defined results rather than wrapping modulo 32. A count of zero is not a shift at all: the operand passes through and the carry supplied by the caller comes back unchanged, so a flag evaluator downstream can leave the previous carry in place.

The shift datapath is combinational. A parameter places one register stage on the result and the two flags; with the default setting, the outputs follow the inputs one clock edge later, and a synchronous active-low reset clears them. Flags other than carry and extend are computed elsewhere from the shifted result.

Top module: `shift_carry_unit`

## Requirements
- R1: Only the low 6 bits of the 8-bit `shamt` input count; `shamt` values 68 and 4 give identical outputs, and 64 acts as a count of zero.
- R2: With an effective count of zero, for any `op`, `res_q` equals `src` and `cflag_q` equals `cin`.
- R3: With `op` = 2'b00 (logical left) and count n in 1..31, `res_q` is `src` shifted left by n with zero fill and `cflag_q` is `src` bit (32 − n).
- R4: Logical left by exactly 32 gives zero with `cflag_q` equal to `src` bit 0; counts 33..63 give zero with `cflag_q` = 0.
- R5: With `op` = 2'b01 (logical right) and count n in 1..31, `res_q` is `src` shifted right by n with zero fill and `cflag_q` is `src` bit (n − 1).
- R6: Logical right by exactly 32 gives zero with `cflag_q` equal to `src` bit 31; counts 33..63 give zero with `cflag_q` = 0.
- R7: With `op` = 2'b10 (arithmetic right) and count n in 1..31, vacated bits take `src` bit 31 and `cflag_q` is `src` bit (n − 1).
- R8: Arithmetic right by any count 32..63 makes every result bit equal to `src` bit 31 and sets `cflag_q` to `src` bit 31.
- R9: `xflag_q` always equals `cflag_q`.
- R10: With `op` = 2'b11 the operand passes through and `cflag_q` equals `cin`, whatever the count.
- R11: With the register stage enabled (default), outputs reflect the inputs present at the previous rising clock edge; while `rst_n` is low at an edge, `res_q`, `cflag_q` and `xflag_q` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Synchronous reset, active low |
| src | input | 32 | Operand to be shifted |
| shamt | input | 8 | Shift count; low 6 bits used |
| op | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 pass |
| cin | input | 1 | Carry from the previous operation |
| res_q | output | 32 | Shifted result |
| cflag_q | output | 1 | Carry out |
| xflag_q | output | 1 | Extend flag, copy of the carry |

## Verification
The properties assume that `op`, `shamt`, `src` and `cin` are two-state and held stable across each sampling edge, and that the register stage sees reset only as a level sampled at the clock. The bench drives every input on the falling edge and reads outputs on the next falling edge, so each value is settled at the rising edge that captures it. The count is always driven through the full 8-bit port, including values above 63, so the modulo reduction is exercised without ever relying on the upper bits being zero.

// File: rtl/shc_pkg.sv
// Shared encodings for the shift-with-carry unit.
// Assumes: the operation code is two bits wide and fully decoded.
package shc_pkg;
    typedef enum logic [1:0] {
        SHC_LSL  = 2'b00,
        SHC_LSR  = 2'b01,
        SHC_ASR  = 2'b10,
        SHC_HOLD = 2'b11
    } shc_op_e;
endpackage

// File: rtl/shc_left.sv
// Logical left shifter with carry-out.
// Shifts a W+1 bit word whose top bit catches the last bit lost, so that
// counts 1..W share one path; counts above W force zero.
// Assumes: the caller handles a count of zero.
module shc_left #(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] amt,
    output logic [W-1:0]  res,
    output logic          cy
);
    logic [W:0] ext;

    // Widened shift; the extra MSB holds the carry.
    always_comb begin
        if (amt > CW'(W)) begin
            ext = '0;
        end else begin
            ext = {1'b0, din} << amt;
        end
        res = ext[W-1:0];
        cy  = ext[W];
    end
endmodule

// File: rtl/shc_right.sv
// Logical or arithmetic right shifter with carry-out.
// A guard bit below the operand catches the last bit lost; arithmetic
// counts are clamped to W so larger counts saturate to sign fill.
// Assumes: the caller handles a count of zero.
module shc_right #(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] amt,
    input  logic          arith,
    output logic [W-1:0]  res,
    output logic          cy
);
    logic            fill;
    logic [CW-1:0]   amt_c;
    logic [2*W+1:0]  wide;
    logic [W:0]      ext;

    // Fill bit, clamped count and guarded shift.
    always_comb begin
        fill  = arith & din[W-1];
        amt_c = (amt > CW'(W)) ? CW'(W) : amt;
        wide  = {{(W+1){fill}}, din, 1'b0} >> amt_c;
        if (!arith && (amt > CW'(W))) begin
            ext = '0;
        end else begin
            ext = wide[W:0];
        end
        res = ext[W:1];
        cy  = ext[0];
    end
endmodule

// File: rtl/shc_outreg.sv
// Optional output register for result, carry and extend flag.
// REG_OUT=1 adds one synchronous stage with active-low reset;
// REG_OUT=0 passes the combinational values straight through.
module shc_outreg #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_res,
    input  logic         d_c,
    output logic [W-1:0] q_res,
    output logic         q_c,
    output logic         q_x
);
    generate
        if (REG_OUT) begin : g_reg
            // Capture result and flags each edge; clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_res <= '0;
                    q_c   <= 1'b0;
                    q_x   <= 1'b0;
                end else begin
                    q_res <= d_res;
                    q_c   <= d_c;
                    q_x   <= d_c;
                end
            end

            // R11: registered outputs follow the previous cycle's values.
            a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (q_res == $past(d_res)) && (q_c == $past(d_c)));
            // R9: extend flag tracks the carry flag.
            a_r9_x_follows_c: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (q_x == $past(d_c)));
        end else begin : g_comb
            assign q_res = d_res;
            assign q_c   = d_c;
            assign q_x   = d_c;
        end
    endgenerate
endmodule

// File: rtl/shift_carry_unit.sv
// Top: 32-bit shifter producing carry and extend flags.
// Count reduced to its low CW bits (modulo 2*W); zero count and the
// pass code return the operand with the incoming carry.
// Assumes: inputs settle before the capturing clock edge.
module shift_carry_unit
    import shc_pkg::*;
#(
    parameter int W        = 32,
    parameter int CNT_IN_W = 8,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        src,
    input  logic [CNT_IN_W-1:0] shamt,
    input  logic [1:0]          op,
    input  logic                cin,
    output logic [W-1:0]        res_q,
    output logic                cflag_q,
    output logic                xflag_q
);
    localparam int CW = $clog2(W) + 1;

    shc_op_e        op_e;
    logic [CW-1:0]  amt;
    logic [W-1:0]   l_res, r_res, res_n;
    logic           l_cy, r_cy, c_n;

    assign op_e = shc_op_e'(op);
    assign amt  = shamt[CW-1:0];

    generate
        if (CNT_IN_W > CW) begin : g_hi
            logic unused_cnt_hi;
            assign unused_cnt_hi = ^shamt[CNT_IN_W-1:CW];
        end
    endgenerate

    shc_left #(.W(W), .CW(CW)) u_left (
        .din (src),
        .amt (amt),
        .res (l_res),
        .cy  (l_cy)
    );

    shc_right #(.W(W), .CW(CW)) u_right (
        .din   (src),
        .amt   (amt),
        .arith (op_e == SHC_ASR),
        .res   (r_res),
        .cy    (r_cy)
    );

    // Choose shifter output; zero count and pass code keep operand and carry.
    always_comb begin
        res_n = src;
        c_n   = cin;
        if (amt != '0) begin
            case (op_e)
                SHC_LSL: begin res_n = l_res; c_n = l_cy; end
                SHC_LSR,
                SHC_ASR: begin res_n = r_res; c_n = r_cy; end
                default: begin res_n = src;   c_n = cin;  end
            endcase
        end
    end

    shc_outreg #(.W(W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_res (res_n),
        .d_c   (c_n),
        .q_res (res_q),
        .q_c   (cflag_q),
        .q_x   (xflag_q)
    );

    // R2: zero count leaves operand and carry untouched.
    a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (amt == '0) |-> (res_n == src) && (c_n == cin));
    // R3: left carry is the last bit shifted out.
    a_r3_left_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == SHC_LSL && amt != '0 && amt < CW'(W)) |-> (c_n == src[W - int'(amt)]));
    // R4: left by more than W clears both result and carry.
    a_r4_left_over: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == SHC_LSL && amt > CW'(W)) |-> (res_n == '0) && !c_n);
    // R5: right carry is bit count-1 of the operand.
    a_r5_right_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_e == SHC_LSR || op_e == SHC_ASR) && amt != '0 && amt < CW'(W))
        |-> (c_n == src[int'(amt) - 1]));
    // R8: arithmetic saturation fills with the sign.
    a_r8_asr_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == SHC_ASR && amt >= CW'(W)) |-> (res_n == {W{src[W-1]}}) && (c_n == src[W-1]));
    // R10: pass code holds operand and carry for any count.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == SHC_HOLD) |-> (res_n == src) && (c_n == cin));
endmodule

// File: tb/shift_carry_unit_bench.sv
`timescale 1ns/1ps
module shift_carry_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src;
    logic [7:0]  shamt;
    logic [1:0]  op;
    logic        cin;
    logic [31:0] res_q;
    logic        cflag_q, xflag_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    shift_carry_unit u_shift_carry_unit (
        .clk(clk), .rst_n(rst_n), .src(src), .shamt(shamt), .op(op), .cin(cin),
        .res_q(res_q), .cflag_q(cflag_q), .xflag_q(xflag_q)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  cnt;
        logic [31:0] din;
        logic        cp;
        logic [31:0] er;
        logic        ec;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 8'd4,    32'hF000_0001, 1'b0, 32'h0000_0010, 1'b1, 8'd3},  // R3
        '{2'b00, 8'd32,   32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1, 8'd4},  // R4
        '{2'b00, 8'd33,   32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 8'd4},  // R4
        '{2'b01, 8'd1,    32'h0000_0003, 1'b0, 32'h0000_0001, 1'b1, 8'd5},  // R5
        '{2'b01, 8'd32,   32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1, 8'd6},  // R6
        '{2'b01, 8'd63,   32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 8'd6},  // R6
        '{2'b10, 8'd4,    32'h8000_0018, 1'b0, 32'hF800_0001, 1'b1, 8'd7},  // R7
        '{2'b10, 8'd40,   32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1, 8'd8},  // R8
        '{2'b10, 8'd32,   32'h7FFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 8'd8},  // R8
        '{2'b00, 8'd0,    32'h1234_5678, 1'b1, 32'h1234_5678, 1'b1, 8'd2},  // R2
        '{2'b11, 8'd5,    32'hDEAD_BEEF, 1'b0, 32'hDEAD_BEEF, 1'b0, 8'd10}, // R10
        '{2'b11, 8'd0,    32'h0000_0001, 1'b1, 32'h0000_0001, 1'b1, 8'd10}, // R10
        '{2'b00, 8'h44,   32'hF000_0001, 1'b0, 32'h0000_0010, 1'b1, 8'd1},  // R1
        '{2'b01, 8'h40,   32'hA5A5_A5A5, 1'b1, 32'hA5A5_A5A5, 1'b1, 8'd1}   // R1
    };

    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%h c=%b, expected res=%h c=%b",
                     tag, got[32:1], got[0], exp[32:1], exp[0]);
        end
    endtask

    // Bit-level model written from the requirement text.
    function automatic logic [32:0] model(input logic [1:0] o, input logic [7:0] k,
                                         input logic [31:0] d, input logic cp);
        int n = int'(k[5:0]);
        logic [31:0] r;
        logic c;
        if (n == 0 || o == 2'b11) return {d, cp};
        r = '0;
        c = 1'b0;
        for (int i = 0; i < 32; i++) begin
            case (o)
                2'b00:   r[i] = (i - n >= 0) ? d[i - n] : 1'b0;
                2'b01:   r[i] = (i + n < 32) ? d[i + n] : 1'b0;
                default: r[i] = (i + n < 32) ? d[i + n] : d[31];
            endcase
        end
        case (o)
            2'b00:   c = (n <= 32) ? d[32 - n] : 1'b0;
            2'b01:   c = (n <= 32) ? d[n - 1] : 1'b0;
            default: c = (n < 32) ? d[n - 1] : d[31];
        endcase
        return {r, c};
    endfunction

    task automatic apply(input logic [1:0] o, input logic [7:0] k,
                         input logic [31:0] d, input logic cp);
        @(negedge clk);
        op = o; shamt = k; src = d; cin = cp;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] pats [3];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h5A3C_96E1;
        pats[2] = 32'hC0FF_EE03;
        rst_n = 1'b0; src = 32'hFFFF_FFFF; shamt = 8'd3; op = 2'b00; cin = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset clears outputs despite nonzero inputs.
        check("R11 reset", {res_q, cflag_q}, 33'd0);
        check("R11 reset x", {32'd0, xflag_q}, 33'd0);
        rst_n = 1'b1;

        // Table of hand-computed vectors.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].cnt, VEC[i].din, VEC[i].cp);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), {res_q, cflag_q}, {VEC[i].er, VEC[i].ec});
            check($sformatf("R9 vec%0d", i), {32'd0, xflag_q}, {32'd0, cflag_q});
        end

        // R11: output holds until the next edge after an input change.
        apply(2'b01, 8'd1, 32'h0000_0002, 1'b0);
        #1;
        src = 32'hFFFF_FFFF;
        check("R11 latency hold", {res_q, cflag_q}, {32'h0000_0001, 1'b0});
        @(negedge clk);
        check("R11 latency update", {res_q, cflag_q}, {32'h7FFF_FFFF, 1'b1});

        // Sweep all operations, counts 0..63 and their +64 aliases (R1..R10).
        for (int p = 0; p < 3; p++) begin
            for (int o = 0; o < 4; o++) begin
                for (int k = 0; k < 128; k++) begin
                    apply(2'(o), 8'(k), pats[p], 1'(k & 1));
                    check($sformatf("R3-sweep op%0d cnt%0d", o, k), {res_q, cflag_q},
                          model(2'(o), 8'(k), pats[p], 1'(k & 1)));
                    check("R9 sweep", {32'd0, xflag_q}, {32'd0, cflag_q});
                end
            end
        end

        // R11: reset mid-run clears registered outputs.
        apply(2'b10, 8'd4, 32'h8000_0000, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset midrun", {res_q, cflag_q}, 33'd0);
        finish_run();
    end
endmodule